// File: doc/BRIEF.md
# Receive Buffer Descriptor Fetcher

This block keeps the receive datapath supplied with empty buffers. It walks a ring of buffer descriptors held in memory, reading them through a plain single-word read port. From each descriptor it takes the buffer address and presents it, together with the ring slot it came from, on a valid/ready handshake. Once the datapath accepts a buffer, the fetcher advances its consumer index. The host can read that index back to learn which buffers are in use.

Two run-time choices set the descriptor layout and the ring length:
- **Layout:** a compact one-word descriptor, or a two-word descriptor carrying a 64-bit address.
- **Ring length:** 256 or 2048 slots.

Two operating models govern when a buffer counts as available and where the ring wraps:
- **Producer model:** the host writes a producer index. The fetcher runs until its consumer index catches up with that producer index, and wraps only at the configured ring length.
- **Polling model:** every descriptor carries a usable flag and a last-entry flag. The fetcher waits on an unusable entry and re-reads it, and wraps after the marked entry.

Top module: `rx_bufdesc_fetcher`

## Requirements
- R1: With `cfg_fmt64`=0, each descriptor is one word at word address equal to its index. Bits [31:2] give address bits [31:2], and address bits [1:0] and [63:32] are zero. Bit 1 is the last-entry flag and bit 0 is the usable flag.
- R2: With `cfg_fmt64`=1, a descriptor occupies word addresses 2·index and 2·index+1, read in that order.
  - The first word is address bits [31:0].
  - In the second word, bits [31:2] give address bits [63:34], and address bits [33:32] are zero.
  - In the second word, bit 1 is the last-entry flag and bit 0 is the usable flag.
- R3: `cfg_big_ring` selects a ring of 2048 slots (1) or 256 slots (0). In producer mode the consumer index wraps to 0 after the last slot and nowhere else.
- R4: In producer mode (`cfg_poll_mode`=0), a buffer is offered only while the consumer index differs from `host_prod_idx`. While the two are equal, no memory read is issued and nothing is offered.
- R5: In producer mode, the last-entry and usable flags of a descriptor have no effect on the offered address, the index sequence or the wrap point.
- R6: In polling mode, after the buffer from a descriptor with the last-entry flag set is accepted, the next index is 0.
- R7: In polling mode, a descriptor with the usable flag clear is not offered. The fetcher stays idle for at least `cfg_poll_gap`+1 cycles and then re-reads the same slot.
- R8: An offered buffer holds `buf_addr` and `buf_idx` stable until `buf_ready`. The consumer index changes only on an accepted offer, and then by exactly one step.
- R9: Reset clears the consumer index and the offer. Layout, ring length and operating model are sampled only while reset is asserted, so changing them at any other time has no effect.
- R10: Memory read data is taken on the cycle after `mem_rd_en`. No buffer is offered while a read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; samples the configuration |
| cfg_fmt64 | input | 1 | Descriptor layout: 0 one word, 1 two words |
| cfg_big_ring | input | 1 | Ring length: 0 is 256 slots, 1 is 2048 slots |
| cfg_poll_mode | input | 1 | 0 producer model, 1 polling model |
| cfg_poll_gap | input | 16 | Idle cycles before re-reading an unusable descriptor |
| host_prod_idx | input | 11 | Producer index written by the host |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 12 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| buf_valid | output | 1 | A buffer is offered |
| buf_ready | input | 1 | Datapath accepts the offered buffer |
| buf_addr | output | 64 | Offered buffer address |
| buf_idx | output | 11 | Ring slot of the offered buffer |
| cons_idx | output | 11 | Consumer index, readable by the host |

## Verification
The properties assume the following about the inputs:
- The configuration pins stay as they were sampled at reset.
- `host_prod_idx` stays below the selected ring length.
- Memory answers exactly one cycle after each read.

The stimulus applies every configuration inside reset and keeps producer values in range. The one deliberate mid-run configuration change (R9) only raises the layout and ring-length pins. The empty-ring property checks only the one-word producer case, so that change turns it off instead of breaking it. The bench memory model always returns data on the next edge.

// File: rtl/rbdf_pkg.sv
package rbdf_pkg;

    typedef enum logic [2:0] {
        ST_CHECK,   // decide whether a slot may be read
        ST_LO,      // first word returning
        ST_HI,      // second word returning (two-word layout)
        ST_GAP,     // waiting before re-reading an unusable slot
        ST_OFFER    // buffer presented to the datapath
    } fetch_st_e;

endpackage

// File: rtl/rbdf_gap_timer.sv
module rbdf_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             done
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_n) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rbdf_ring_ctl.sv
module rbdf_ring_ctl #(
    parameter int IDX_W      = 11,
    parameter int SMALL_LOG2 = 8
) (
    input  logic [IDX_W-1:0] cons,
    input  logic [IDX_W-1:0] prod,
    input  logic             big,
    input  logic             poll,
    input  logic             last_flag,
    output logic             avail,
    output logic [IDX_W-1:0] next_idx
);
    localparam logic [IDX_W-1:0] SMALL_MASK =
        {{(IDX_W-SMALL_LOG2){1'b0}}, {SMALL_LOG2{1'b1}}};
    localparam logic [IDX_W-1:0] BIG_MASK = '1;

    logic [IDX_W-1:0] mask;

    always_comb begin
        mask     = big ? BIG_MASK : SMALL_MASK;
        avail    = poll || (cons != (prod & mask));
        next_idx = (poll && last_flag) ? '0 : ((cons + IDX_W'(1)) & mask);
    end
endmodule

// File: rtl/rbdf_addr_gen.sv
module rbdf_addr_gen #(
    parameter int IDX_W = 11,
    localparam int AW   = IDX_W + 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             fmt64,
    input  logic             second_word,
    output logic [AW-1:0]    addr
);
    always_comb begin
        if (fmt64) begin
            addr = {idx, second_word};
        end else begin
            addr = {1'b0, idx};
        end
    end
endmodule

// File: rtl/rx_bufdesc_fetcher.sv
module rx_bufdesc_fetcher
    import rbdf_pkg::*;
#(
    parameter int IDX_W      = 11,
    parameter int SMALL_LOG2 = 8,
    parameter int GAP_W      = 16,
    parameter int DW         = 32,
    localparam int AW        = IDX_W + 1,
    localparam int BAW       = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fmt64,
    input  logic             cfg_big_ring,
    input  logic             cfg_poll_mode,
    input  logic [GAP_W-1:0] cfg_poll_gap,
    input  logic [IDX_W-1:0] host_prod_idx,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    output logic             buf_valid,
    input  logic             buf_ready,
    output logic [BAW-1:0]   buf_addr,
    output logic [IDX_W-1:0] buf_idx,
    output logic [IDX_W-1:0] cons_idx
);
    typedef struct packed {
        fetch_st_e        st;
        logic             fmt64;
        logic             big;
        logic             poll;
        logic [IDX_W-1:0] cons;
        logic [DW-1:0]    lo;
        logic [BAW-1:0]   baddr;
        logic             last;
    } regs_t;

    regs_t d, q;

    logic             avail;
    logic [IDX_W-1:0] next_idx;
    logic             second_word;
    logic             gap_load;
    logic             gap_done;
    logic             decode_now;
    logic [BAW-1:0]   cand_addr;

    rbdf_ring_ctl #(.IDX_W(IDX_W), .SMALL_LOG2(SMALL_LOG2)) u_ring (
        .cons      (q.cons),
        .prod      (host_prod_idx),
        .big       (q.big),
        .poll      (q.poll),
        .last_flag (q.last),
        .avail     (avail),
        .next_idx  (next_idx)
    );

    rbdf_addr_gen #(.IDX_W(IDX_W)) u_addr (
        .idx         (q.cons),
        .fmt64       (q.fmt64),
        .second_word (second_word),
        .addr        (mem_rd_addr)
    );

    rbdf_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg_poll_gap),
        .done     (gap_done)
    );

    // Flags always sit in bits [1:0] of the word that completes a descriptor.
    always_comb begin
        decode_now = ((q.st == ST_LO) && !q.fmt64) || (q.st == ST_HI);
        if (q.fmt64) begin
            cand_addr = {mem_rd_data[DW-1:2], 2'b00, q.lo};
        end else begin
            cand_addr = {{DW{1'b0}}, mem_rd_data[DW-1:2], 2'b00};
        end
    end

    always_comb begin
        d           = q;
        mem_rd_en   = 1'b0;
        second_word = 1'b0;
        gap_load    = 1'b0;
        if (!rst_n) begin
            d       = '0;
            d.st    = ST_CHECK;
            d.fmt64 = cfg_fmt64;
            d.big   = cfg_big_ring;
            d.poll  = cfg_poll_mode;
        end else begin
            case (q.st)
                ST_CHECK: begin
                    if (avail) begin
                        mem_rd_en = 1'b1;
                        d.st      = ST_LO;
                    end
                end
                ST_LO: begin
                    if (q.fmt64) begin
                        d.lo        = mem_rd_data;
                        mem_rd_en   = 1'b1;
                        second_word = 1'b1;
                        d.st        = ST_HI;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        d.st = ST_CHECK;
                    end
                end
                ST_OFFER: begin
                    if (buf_ready) begin
                        d.cons = next_idx;
                        d.st   = ST_CHECK;
                    end
                end
                default: d.st = ST_CHECK;
            endcase

            if (decode_now) begin
                if (q.poll && !mem_rd_data[0]) begin
                    gap_load = 1'b1;
                    d.st     = ST_GAP;
                end else begin
                    d.baddr = cand_addr;
                    d.last  = q.poll & mem_rd_data[1];
                    d.st    = ST_OFFER;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign buf_valid = (q.st == ST_OFFER);
    assign buf_addr  = q.baddr;
    assign buf_idx   = q.cons;
    assign cons_idx  = q.cons;
endmodule

// File: rtl/rbdf_checker.sv
module rbdf_checker #(
    parameter int IDX_W = 11,
    parameter int AW    = 12,
    parameter int BAW   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_fmt64,
    input logic             cfg_poll_mode,
    input logic [IDX_W-1:0] host_prod_idx,
    input logic             mem_rd_en,
    input logic [AW-1:0]    mem_rd_addr,
    input logic             buf_valid,
    input logic             buf_ready,
    input logic [BAW-1:0]   buf_addr,
    input logic [IDX_W-1:0] buf_idx,
    input logic [IDX_W-1:0] cons_idx
);
    // R8: a held offer keeps its contents
    p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_idx));

    // R8: consumer index moves only on acceptance
    p_cons_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_valid && buf_ready) |=> $stable(cons_idx));

    // R3 / R6: an accepted offer steps the index by one or wraps it to zero
    p_cons_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid && buf_ready |=> (cons_idx == $past(cons_idx) + 1'b1) || (cons_idx == '0));

    // R10: no read while an offer is up, and no offer in the cycle data returns
    p_no_read_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> !mem_rd_en);

    p_rd_then_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !buf_valid);

    // R4: one-word producer mode issues no read when the ring is empty
    p_empty_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_poll_mode && !cfg_fmt64 && (cons_idx == host_prod_idx) |-> !mem_rd_en);

    // R1: one-word reads address the consumer slot directly
    p_addr_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fmt64 && mem_rd_en |-> mem_rd_addr[AW-2:0] == cons_idx || $past(cfg_fmt64));
endmodule

bind rx_bufdesc_fetcher rbdf_checker #(.IDX_W(IDX_W), .AW(AW), .BAW(BAW)) u_rbdf_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fmt64     (cfg_fmt64),
    .cfg_poll_mode (cfg_poll_mode),
    .host_prod_idx (host_prod_idx),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .buf_valid     (buf_valid),
    .buf_ready     (buf_ready),
    .buf_addr      (buf_addr),
    .buf_idx       (buf_idx),
    .cons_idx      (cons_idx)
);

// File: tb/tb_rx_bufdesc_fetcher.sv
module tb_rx_bufdesc_fetcher;
    localparam int IDX_W = 11;
    localparam int GAP_W = 16;
    localparam int AW    = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_fmt64 = 1'b0;
    logic             cfg_big_ring = 1'b0;
    logic             cfg_poll_mode = 1'b0;
    logic [GAP_W-1:0] cfg_poll_gap = '0;
    logic [IDX_W-1:0] host_prod_idx = '0;
    logic             mem_rd_en;
    logic [AW-1:0]    mem_rd_addr;
    logic [31:0]      mem_rd_data;
    logic             buf_valid;
    logic             buf_ready = 1'b0;
    logic [63:0]      buf_addr;
    logic [IDX_W-1:0] buf_idx;
    logic [IDX_W-1:0] cons_idx;

    always #5 clk = ~clk;

    rx_bufdesc_fetcher dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt64(cfg_fmt64), .cfg_big_ring(cfg_big_ring),
        .cfg_poll_mode(cfg_poll_mode), .cfg_poll_gap(cfg_poll_gap),
        .host_prod_idx(host_prod_idx), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .buf_valid(buf_valid), .buf_ready(buf_ready),
        .buf_addr(buf_addr), .buf_idx(buf_idx), .cons_idx(cons_idx)
    );

    // Memory model: one-cycle read latency (R10)
    logic [31:0] mem [0:4095];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int total = 0, bad = 0, cyc = 0, reads = 0;
    int watch_addr = -1, hits = 0, last_hit = -1, min_gap = 1000000;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && mem_rd_en) begin
            reads <= reads + 1;
            if (int'(mem_rd_addr) == watch_addr) begin
                if (last_hit >= 0 && (cyc - last_hit) < min_gap) min_gap <= cyc - last_hit;
                last_hit <= cyc;
                hits <= hits + 1;
            end
        end
    end

    typedef struct packed {
        bit fmt64; bit big; bit poll; int lim; int cnt; int special;
    } vec_t;

    // lim: producer index (producer mode) or last-entry slot (polling mode)
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b0,   6,   6,    2},  // R1, R5: flags at slot 2 ignored
        '{1'b1, 1'b0, 1'b0,   5,   5,    3},  // R2, R5
        '{1'b0, 1'b1, 1'b0, 300, 300, 4000},  // R3: passes 255 on a big ring
        '{1'b0, 1'b0, 1'b1,   3,   9,   -1},  // R6 one-word
        '{1'b1, 1'b1, 1'b1,   5,   8,   -1},  // R6, R2 two-word
        '{1'b1, 1'b1, 1'b0,   3,   3, 4000}   // R2 on a big ring
    };

    function automatic logic [63:0] exp_addr(int i, bit f64);
        logic [31:0] lo, hi;
        if (!f64) begin
            lo = 32'h0010_0000 + i * 64;
            return {32'h0, lo};
        end
        hi = 32'h2000_0000 + (i << 4);
        lo = 32'h5500_0000 ^ (i * 32'h0001_0103);
        return {hi, lo};
    endfunction

    task automatic fill(bit f64, int last_at, int unusable_at);
        for (int i = 0; i < 2048; i++) begin
            logic [63:0] a;
            logic e, v;
            a = exp_addr(i, f64);
            e = (i == last_at);
            v = (i != unusable_at);
            if (!f64) mem[i] = {a[31:2], e, v};
            else begin
                mem[2*i]   = a[31:0];
                mem[2*i+1] = {a[63:34], e, v};
            end
        end
    endtask

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset(bit f64, bit big, bit poll, int gap, int prod);
        @(negedge clk);
        rst_n = 1'b0;
        buf_ready = 1'b0;
        cfg_fmt64 = f64;
        cfg_big_ring = big;
        cfg_poll_mode = poll;
        cfg_poll_gap = GAP_W'(gap);
        host_prod_idx = IDX_W'(prod);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic take_one(int exp_idx, bit f64, string tag);
        int n = 0;
        while (!buf_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (!buf_valid) begin
            chk(1'b0, {tag, " no offer"}, 0, 1);
            return;
        end
        chk(int'(buf_idx) == exp_idx, {tag, " idx"}, 64'(buf_idx), 64'(exp_idx));
        chk(buf_addr == exp_addr(exp_idx, f64), {tag, " addr"}, buf_addr, exp_addr(exp_idx, f64));
        buf_ready = 1'b1;
        @(negedge clk);
        buf_ready = 1'b0;
    endtask

    task automatic check_idle(int n, string tag);
        int r0;
        bit seen = 0;
        r0 = reads;
        repeat (n) begin
            @(negedge clk);
            if (buf_valid) seen = 1;
        end
        chk(!seen && reads == r0, tag, 64'(reads - r0), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!buf_valid, "R9 reset offer", 64'(buf_valid), 0);
        chk(!mem_rd_en, "R9 reset read", 64'(mem_rd_en), 0);
        chk(cons_idx == '0, "R9 reset index", 64'(cons_idx), 0);

        // Table walk
        foreach (VECS[v]) begin
            vec_t t;
            t = VECS[v];
            if (t.poll) fill(t.fmt64, t.lim, -1);
            else fill(t.fmt64, t.special, t.special);
            do_reset(t.fmt64, t.big, t.poll, 3, t.poll ? 0 : t.lim);
            for (int k = 0; k < t.cnt; k++) begin
                take_one(t.poll ? k % (t.lim + 1) : k, t.fmt64,
                         t.poll ? "R6 poll wrap" : "R4 producer seq");
            end
            if (!t.poll) begin
                check_idle(20, "R4 empty ring idle");
                chk(int'(cons_idx) == t.lim, "R4 final index", 64'(cons_idx), 64'(t.lim));
            end
        end

        // R3: small ring wraps at 256
        fill(1'b0, -1, -1);
        do_reset(1'b0, 1'b0, 1'b0, 0, 200);
        for (int k = 0; k < 200; k++) take_one(k, 1'b0, "R3 pre-wrap");
        host_prod_idx = 11'd10;
        for (int k = 0; k < 66; k++) take_one((200 + k) % 256, 1'b0, "R3 wrap");
        chk(cons_idx == 11'd10, "R3 index after wrap", 64'(cons_idx), 10);

        // R7: unusable slot in polling mode
        fill(1'b0, 7, 2);
        do_reset(1'b0, 1'b0, 1'b1, 6, 0);
        take_one(0, 1'b0, "R7 before");
        take_one(1, 1'b0, "R7 before");
        watch_addr = 2;
        begin
            bit seen = 0;
            repeat (60) begin
                @(negedge clk);
                if (buf_valid) seen = 1;
            end
            chk(!seen, "R7 no offer while unusable", 64'(seen), 0);
        end
        chk(hits >= 3, "R7 re-reads", 64'(hits), 3);
        chk(min_gap >= 7, "R7 poll spacing", 64'(min_gap), 7);
        mem[2] = mem[2] | 32'h1;
        watch_addr = -1;
        take_one(2, 1'b0, "R7 released");
        take_one(3, 1'b0, "R7 released");

        // R8: backpressure holds the offer
        fill(1'b0, -1, -1);
        do_reset(1'b0, 1'b0, 1'b0, 0, 3);
        begin
            int n = 0;
            bit ok = 1;
            while (!buf_valid && n < 100) begin
                @(negedge clk);
                n++;
            end
            repeat (10) begin
                @(negedge clk);
                if (!buf_valid || buf_idx != '0 || buf_addr != exp_addr(0, 1'b0) || cons_idx != '0)
                    ok = 0;
            end
            chk(ok, "R8 hold under backpressure", 64'(ok), 1);
        end
        take_one(0, 1'b0, "R8 accept");
        chk(cons_idx == 11'd1, "R8 single step", 64'(cons_idx), 1);
        take_one(1, 1'b0, "R8 accept");

        // R9: configuration change outside reset has no effect
        fill(1'b0, -1, -1);
        do_reset(1'b0, 1'b0, 1'b0, 0, 4);
        take_one(0, 1'b0, "R9 cfg");
        cfg_fmt64 = 1'b1;
        cfg_big_ring = 1'b1;
        for (int k = 1; k < 4; k++) take_one(k, 1'b0, "R9 cfg ignored");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cons_idx == '0, "R9 reset clears index", 64'(cons_idx), 0);
        chk(!buf_valid, "R9 reset clears offer", 64'(buf_valid), 0);
        cfg_fmt64 = 1'b0;
        cfg_big_ring = 1'b0;
        rst_n = 1'b1;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule